// File: doc/BRIEF.md
# BCD Calendar Clock with Two-Stage Prescaler

This block keeps the time of day and the calendar date as packed binary-coded-decimal digits and advances them once per second. A tick enable arrives from a low-speed (nominally 32.768 kHz) domain, already aligned to the block clock. The seconds rate comes from two stages of division. A small first-stage counter divides the tick enable by `asyncDiv+1`. A wider second-stage counter then divides that result by `syncDiv+1`. With 127 and 255 loaded, a 32.768 kHz enable gives exactly one second.

The time word holds seconds, minutes and hours as BCD digit pairs, plus a PM flag. The date word holds day of month, a month with a single-bit tens digit, a weekday from 1 to 7, and a two-digit year offset. The year offset drives the leap-year rule. A format input chooses 24-hour or 12-hour counting.

Software or a neighbouring block sets the clock by pulsing a load strobe with a new time or date word. Any load also restarts both prescaler counters, so the first second after a load is a full second.

Top module: `bcd_calendar_clock`

## Requirements
- R1: With tick enables counted from the last load or second, the time advances on the edge that takes the `(asyncDiv+1)*(syncDiv+1)`-th enable. `secPulse` is high for exactly the one cycle after that edge.
- R2: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours.
- R3: `timeOut` layout: bit 20 is the PM flag; [19:18] are hour tens; [17:14] are hour units; [13:11] are minute tens; [10:7] are minute units; [6:4] are second tens; [3:0] are second units. `timeIn` uses the same layout.
- R4: When `hourFmt24` is 1, hours wrap from 23 to 00 and that wrap advances the date by one day.
- R5: When `hourFmt24` is 0, hour 11 goes to 12 and toggles the PM flag, and hour 12 goes to 01. The change from 11 PM to 12 AM advances the date by one day.
- R6: `dateOut` layout: [21:18] are year tens; [17:14] are year units; [13:11] are the weekday; bit 10 is month tens; [9:6] are month units; [5:4] are day tens; [3:0] are day units. `dateIn` uses the same layout. A day advance past the last day of the month (30 for months 4, 6, 9 and 11; 31 for the others except February) sets the day to 01 and advances the month.
- R7: February ends at day 29 when the year offset is divisible by 4, year 00 included, and at day 28 otherwise.
- R8: The weekday increments on every day advance and wraps from 7 to 1.
- R9: Month 12 wraps to 01 and increments the year. Year 99 wraps to 00.
- R10: `loadTime` replaces the time and `loadDate` replaces the date on the next edge. Either strobe clears both prescaler counters and suppresses the second that would have been taken that cycle. A date-only load leaves the time unchanged.
- R11: After reset the time reads 00:00:00 with PM clear, the date reads day 01, month 01, weekday 1, year 00, and `secPulse` is 0.
- R12: While `lsTickEn` is low and no load is applied, the prescaler counters, the time and the date hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| lsTickEn | input | 1 | One-cycle enable per low-speed oscillator period |
| asyncDiv | input | ASYNC_W (7) | First-stage division minus one |
| syncDiv | input | SYNC_W (15) | Second-stage division minus one |
| hourFmt24 | input | 1 | 1 selects 24-hour counting, 0 selects 12-hour with PM flag |
| loadTime | input | 1 | Load strobe for the time word |
| timeIn | input | 21 | Time word to load, layout per R3 |
| loadDate | input | 1 | Load strobe for the date word |
| dateIn | input | 22 | Date word to load, layout per R6 |
| timeOut | output | 21 | Current time word, layout per R3 |
| dateOut | output | 22 | Current date word, layout per R6 |
| secPulse | output | 1 | One-cycle pulse on each second advance |

## Verification
The assertions assume that every loaded word holds legal BCD digits within their field ranges, with a weekday from 1 to 7 and a day that exists in the loaded month. They also assume that the divider inputs do not change while the prescaler is counting. The bench keeps to these limits. It builds every time and date word from ordinary integers chosen inside the legal ranges. It sets the dividers only while the tick enable is idle and then issues a load, which restarts both counters.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int TIME_W = 21;
  localparam int DATE_W = 22;

  // Strobes from the control side to the BCD datapath
  typedef struct packed {
    logic secTick;
    logic loadTime;
    logic loadDate;
  } calStrobe_t;

  // Increment a two-digit BCD value held in one byte
  function automatic logic [7:0] bcdInc8(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Binary value of a two-digit BCD byte
  function automatic logic [6:0] bcdToBin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

endpackage

// File: rtl/cal_prescaler_ctrl.sv
module cal_prescaler_ctrl
  import cal_pkg::*;
#(
  parameter int ASYNC_W = 7,
  parameter int SYNC_W  = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lsTickEn,
  input  logic [ASYNC_W-1:0] asyncDiv,
  input  logic [SYNC_W-1:0]  syncDiv,
  input  logic               loadTime,
  input  logic               loadDate,
  output calStrobe_t         strobe,
  output logic               secPulse
);

  logic [ASYNC_W-1:0] asyncCnt;
  logic [SYNC_W-1:0]  syncCnt;
  logic anyLoad, asyncWrap, syncWrap, secTickC;

  assign anyLoad   = loadTime | loadDate;
  assign asyncWrap = lsTickEn && (asyncCnt >= asyncDiv);
  assign syncWrap  = syncCnt >= syncDiv;
  assign secTickC  = asyncWrap && syncWrap && !anyLoad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asyncCnt <= '0;
      syncCnt  <= '0;
      secPulse <= 1'b0;
    end else begin
      secPulse <= secTickC;
      if (anyLoad) begin
        asyncCnt <= '0;
        syncCnt  <= '0;
      end else if (lsTickEn) begin
        if (asyncWrap) begin
          asyncCnt <= '0;
          if (syncWrap) syncCnt <= '0;
          else          syncCnt <= syncCnt + 1'b1;
        end else begin
          asyncCnt <= asyncCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.secTick  = secTickC;
    strobe.loadTime = loadTime;
    strobe.loadDate = loadDate;
  end

  // After a second is taken both stages must sit at zero
  assert_pulse_restart_R1: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |-> (asyncCnt == '0) && (syncCnt == '0))
    else $error("R1: prescaler not restarted at second");

  // Any load restarts the prescaler and suppresses the second
  assert_load_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    (loadTime || loadDate) |=> (asyncCnt == '0) && (syncCnt == '0) && !secPulse)
    else $error("R10: load did not restart prescaler");

  // No tick enable, no load: counters hold and no second is taken
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!lsTickEn && !loadTime && !loadDate) |=> $stable(asyncCnt) && $stable(syncCnt) && !secPulse)
    else $error("R12: prescaler moved without tick enable");

endmodule

// File: rtl/cal_bcd_datapath.sv
module cal_bcd_datapath
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strobe,
  input  logic              hourFmt24,
  input  logic [TIME_W-1:0] timeIn,
  input  logic [DATE_W-1:0] dateIn,
  output logic [TIME_W-1:0] timeOut,
  output logic [DATE_W-1:0] dateOut
);

  logic [7:0] sec, minute, hour, day, month, year;
  logic       pm;
  logic [2:0] wday;

  logic [7:0] secNext, minNext, hourNext, dayNext, monthNext, yearNext;
  logic       pmNext;
  logic [2:0] wdayNext;
  logic       secLast, minLast, hourStep, dayCarry, dayLast, monthLast;
  logic [7:0] maxDay;
  logic [6:0] yearBin;
  logic       leapYear;

  // Time carry chain
  always_comb begin
    secLast  = sec == 8'h59;
    minLast  = minute == 8'h59;
    hourStep = secLast && minLast;
    secNext  = secLast ? 8'h00 : bcdInc8(sec);
    minNext  = secLast ? (minLast ? 8'h00 : bcdInc8(minute)) : minute;
    hourNext = hour;
    pmNext   = pm;
    dayCarry = 1'b0;
    if (hourStep) begin
      if (hourFmt24) begin
        if (hour == 8'h23) begin
          hourNext = 8'h00;
          dayCarry = 1'b1;
        end else begin
          hourNext = bcdInc8(hour);
        end
      end else begin
        if (hour == 8'h11) begin
          hourNext = 8'h12;
          pmNext   = !pm;
          dayCarry = pm;
        end else if (hour == 8'h12) begin
          hourNext = 8'h01;
        end else begin
          hourNext = bcdInc8(hour);
        end
      end
    end
  end

  // Month length and leap rule
  always_comb begin
    yearBin  = bcdToBin(year);
    leapYear = yearBin[1:0] == 2'b00;
    case (month)
      8'h02:                      maxDay = leapYear ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: maxDay = 8'h30;
      default:                    maxDay = 8'h31;
    endcase
    dayLast   = day == maxDay;
    monthLast = month == 8'h12;
  end

  // Date carry chain, applied only when the day advances
  always_comb begin
    dayNext   = dayLast ? 8'h01 : bcdInc8(day);
    monthNext = month;
    yearNext  = year;
    if (dayLast) begin
      monthNext = monthLast ? 8'h01 : bcdInc8(month);
      if (monthLast) yearNext = (year == 8'h99) ? 8'h00 : bcdInc8(year);
    end
    wdayNext = (wday == 3'd7) ? 3'd1 : wday + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sec    <= 8'h00;
      minute <= 8'h00;
      hour   <= 8'h00;
      pm     <= 1'b0;
    end else if (strobe.loadTime) begin
      pm     <= timeIn[20];
      hour   <= {2'b00, timeIn[19:14]};
      minute <= {1'b0, timeIn[13:7]};
      sec    <= {1'b0, timeIn[6:0]};
    end else if (strobe.secTick) begin
      sec    <= secNext;
      minute <= minNext;
      hour   <= hourNext;
      pm     <= pmNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      day   <= 8'h01;
      month <= 8'h01;
      year  <= 8'h00;
      wday  <= 3'd1;
    end else if (strobe.loadDate) begin
      year  <= dateIn[21:14];
      wday  <= dateIn[13:11];
      month <= {3'b000, dateIn[10:6]};
      day   <= {2'b00, dateIn[5:0]};
    end else if (strobe.secTick && dayCarry) begin
      day   <= dayNext;
      month <= monthNext;
      year  <= yearNext;
      wday  <= wdayNext;
    end
  end

  assign timeOut = {pm, hour[5:0], minute[6:0], sec[6:0]};
  assign dateOut = {year, wday, month[4:0], day[5:0]};

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.secTick && !strobe.loadTime && sec == 8'h59) |=> (sec == 8'h00))
    else $error("R2: seconds did not wrap");

  assert_hour_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.secTick && !strobe.loadTime && !strobe.loadDate && hourFmt24 && hour == 8'h23
     && minute == 8'h59 && sec == 8'h59) |=> (hour == 8'h00) && !$stable(day))
    else $error("R4: 24-hour wrap failed");

  assert_wday_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wday >= 3'd1) && (wday <= 3'd7))
    else $error("R8: weekday out of range");

  assert_month_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    (month != 8'h00) && (month <= 8'h12))
    else $error("R9: month out of range");

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
#(
  parameter int ASYNC_W = 7,
  parameter int SYNC_W  = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lsTickEn,
  input  logic [ASYNC_W-1:0] asyncDiv,
  input  logic [SYNC_W-1:0]  syncDiv,
  input  logic               hourFmt24,
  input  logic               loadTime,
  input  logic [20:0]        timeIn,
  input  logic               loadDate,
  input  logic [21:0]        dateIn,
  output logic [20:0]        timeOut,
  output logic [21:0]        dateOut,
  output logic               secPulse
);

  calStrobe_t strobe;

  cal_prescaler_ctrl #(.ASYNC_W(ASYNC_W), .SYNC_W(SYNC_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .lsTickEn (lsTickEn),
    .asyncDiv (asyncDiv),
    .syncDiv  (syncDiv),
    .loadTime (loadTime),
    .loadDate (loadDate),
    .strobe   (strobe),
    .secPulse (secPulse)
  );

  cal_bcd_datapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hourFmt24 (hourFmt24),
    .timeIn    (timeIn),
    .dateIn    (dateIn),
    .timeOut   (timeOut),
    .dateOut   (dateOut)
  );

endmodule

// File: tb/tb_bcd_calendar_clock.sv
module tb_bcd_calendar_clock;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lsTickEn = 1'b0;
  logic [6:0]  asyncDiv = 7'd1;
  logic [14:0] syncDiv = 15'd1;
  logic        hourFmt24 = 1'b1;
  logic        loadTime = 1'b0;
  logic [20:0] timeIn = '0;
  logic        loadDate = 1'b0;
  logic [21:0] dateIn = '0;
  logic [20:0] timeOut;
  logic [21:0] dateOut;
  logic        secPulse;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bcd_calendar_clock dut (
    .clk(clk), .rstN(rstN), .lsTickEn(lsTickEn), .asyncDiv(asyncDiv),
    .syncDiv(syncDiv), .hourFmt24(hourFmt24), .loadTime(loadTime),
    .timeIn(timeIn), .loadDate(loadDate), .dateIn(dateIn),
    .timeOut(timeOut), .dateOut(dateOut), .secPulse(secPulse)
  );

  // R3 time word from integers
  function automatic logic [20:0] mkTime(int p, int h, int m, int s);
    return {p[0], 2'(h / 10), 4'(h % 10), 3'(m / 10), 4'(m % 10), 3'(s / 10), 4'(s % 10)};
  endfunction

  // R6 date word from integers
  function automatic logic [21:0] mkDate(int y, int mo, int d, int wd);
    return {4'(y / 10), 4'(y % 10), 3'(wd), 1'(mo / 10), 4'(mo % 10), 2'(d / 10), 4'(d % 10)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // columns: fmt24 pm h m s y mo d wd nSec | pm h m s y mo d wd
  localparam int NV = 14;
  localparam int VEC [NV][18] = '{
    '{1,0,10,20,30, 24,3,15,2,    5, 0,10,20,35, 24,3,15,2},  // R2 plain count
    '{1,0,10,20,59, 24,3,15,2,    1, 0,10,21, 0, 24,3,15,2},  // R2 second carry
    '{1,0,10,59,59, 24,3,15,2,    1, 0,11, 0, 0, 24,3,15,2},  // R2 minute carry
    '{1,0,23,59,59,  5,4,30,3,    1, 0, 0, 0, 0,  5,5, 1,4},  // R4 R6 30-day month
    '{1,0,23,59,58,  5,1,31,7,    2, 0, 0, 0, 0,  5,2, 1,1},  // R8 weekday wrap, R6
    '{1,0,23,59,59, 23,2,28,1,    1, 0, 0, 0, 0, 23,3, 1,2},  // R7 non-leap
    '{1,0,23,59,59, 24,2,28,1,    1, 0, 0, 0, 0, 24,2,29,2},  // R7 leap
    '{1,0,23,59,59, 24,2,29,2,    1, 0, 0, 0, 0, 24,3, 1,3},  // R7 leap end
    '{1,0,23,59,59, 99,12,31,5,   1, 0, 0, 0, 0,  0,1, 1,6},  // R9 year wrap
    '{0,0,11,59,59, 10,6,10,1,    1, 1,12, 0, 0, 10,6,10,1},  // R5 AM to PM
    '{0,1,12,59,59, 10,6,10,1,    1, 1, 1, 0, 0, 10,6,10,1},  // R5 12 to 01
    '{0,1,11,59,59, 10,6,30,1,    1, 0,12, 0, 0, 10,7, 1,2},  // R5 day carry at midnight
    '{1,0, 0, 0, 0,  0,1, 1,1, 3661, 0, 1, 1, 1,  0,1, 1,1},  // R2 long run
    '{1,0,12, 0, 0,  0,9,30,4,    0, 0,12, 0, 0,  0,9,30,4}   // R10 load only
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 time", 32'(timeOut), 32'(mkTime(0, 0, 0, 0)));
    chk("R11 date", 32'(dateOut), 32'(mkDate(0, 1, 1, 1)));
    chk("R11 pulse", 32'(secPulse), 32'd0);

    // Vector table, 4 clocks per second with both dividers at 1
    for (int i = 0; i < NV; i++) begin
      hourFmt24 = VEC[i][0][0];
      timeIn    = mkTime(VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);
      dateIn    = mkDate(VEC[i][5], VEC[i][6], VEC[i][7], VEC[i][8]);
      loadTime  = 1'b1;
      loadDate  = 1'b1;
      @(negedge clk);
      loadTime  = 1'b0;
      loadDate  = 1'b0;
      lsTickEn  = 1'b1;
      repeat (VEC[i][9] * 4) @(negedge clk);
      lsTickEn  = 1'b0;
      chk($sformatf("vector %0d time", i), 32'(timeOut),
          32'(mkTime(VEC[i][10], VEC[i][11], VEC[i][12], VEC[i][13])));
      chk($sformatf("vector %0d date", i), 32'(dateOut),
          32'(mkDate(VEC[i][14], VEC[i][15], VEC[i][16], VEC[i][17])));
    end

    // R1: divide by 4*3 = 12 with sparse tick enables
    hourFmt24 = 1'b1;
    asyncDiv  = 7'd3;
    syncDiv   = 15'd2;
    timeIn    = mkTime(0, 0, 0, 0);
    loadTime  = 1'b1;
    @(negedge clk);
    loadTime  = 1'b0;
    for (int k = 0; k < 11; k++) begin
      lsTickEn = 1'b1;
      @(negedge clk);
      lsTickEn = 1'b0;
      @(negedge clk);
    end
    chk("R1 before 12th tick", 32'(timeOut), 32'(mkTime(0, 0, 0, 0)));
    chk("R1 no early pulse", 32'(secPulse), 32'd0);
    lsTickEn = 1'b1;
    @(negedge clk);
    lsTickEn = 1'b0;
    chk("R1 second taken", 32'(timeOut), 32'(mkTime(0, 0, 0, 1)));
    chk("R1 pulse high", 32'(secPulse), 32'd1);
    @(negedge clk);
    chk("R1 pulse one cycle", 32'(secPulse), 32'd0);

    // R12: idle enable holds everything
    repeat (50) @(negedge clk);
    chk("R12 time hold", 32'(timeOut), 32'(mkTime(0, 0, 0, 1)));
    chk("R12 date hold", 32'(dateOut), 32'(mkDate(0, 9, 30, 4)));

    // R10: partial count then load restarts the prescaler
    for (int k = 0; k < 6; k++) begin
      lsTickEn = 1'b1;
      @(negedge clk);
    end
    lsTickEn = 1'b0;
    dateIn   = mkDate(33, 11, 5, 6);
    loadDate = 1'b1;
    @(negedge clk);
    loadDate = 1'b0;
    chk("R10 date-only load keeps time", 32'(timeOut), 32'(mkTime(0, 0, 0, 1)));
    chk("R10 date loaded", 32'(dateOut), 32'(mkDate(33, 11, 5, 6)));
    lsTickEn = 1'b1;
    repeat (11) @(negedge clk);
    lsTickEn = 1'b0;
    chk("R10 restart no early second", 32'(timeOut), 32'(mkTime(0, 0, 0, 1)));
    lsTickEn = 1'b1;
    @(negedge clk);
    lsTickEn = 1'b0;
    chk("R10 full second after restart", 32'(timeOut), 32'(mkTime(0, 0, 0, 2)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule